// File: doc/BRIEF.md
# Hypercube Sum Reduction Node

This block is the per-node sequencer of a sum reduction spread over a hypercube of 2^n nodes. Each node holds one value. When the reduction is complete, node 0 holds the sum of all of them. After a start pulse the node takes its index i and its own value. It then steps through the cube dimensions m from n-1 down to 0. While 2^m is above i, it waits for a partial sum from the neighbour i+2^m and adds it in. At the first dimension where 2^m is not above i, it sends its running sum to the neighbour i-2^m and finishes. Node 0 never reaches that point, so it takes one value per dimension and ends holding the total.

The node has two channels. The receive channel carries a value and the index of the node that sent it. The send channel carries a value and the index of the node it goes to. Both use valid/ready. The network between the nodes is not part of the block. A beat from a node other than the expected partner is flagged and discarded, and the node keeps waiting.

The controller is an enumerated machine with five states:
- IDLE waits for start after reset.
- STEP looks at the current dimension.
- RECV holds ready until the expected partner delivers.
- SEND holds valid until the partner accepts.
- DONE holds the result until the next start.

Its transitions are:
- IDLE→STEP and DONE→STEP on start.
- STEP→RECV when 2^m > i.
- STEP→SEND when 2^m ≤ i.
- STEP→DONE when no dimensions remain, which only node 0 reaches.
- RECV→STEP on an accepted beat from the right source.
- SEND→DONE on tx_ready.

Top module: `hcube_reduce_node`

## Requirements
- R1: While reset is held and after it is released, rx_ready, tx_valid, done, busy and src_err are 0, and result is 0.
- R2: A start pulse in IDLE or DONE captures node_id, loads own_val (zero-extended) into the running sum shown on result, and sets the dimension to n-1.
- R3: Dimensions are visited in descending order. While 2^m > i, the node raises rx_ready and accepts only source i+2^m, moving down one dimension per accepted beat. For n=4 and i=3 it takes node 11 first and then node 7.
- R4: A beat with rx_valid, rx_ready and the expected source adds rx_data to the running sum. result shows the new sum from the next cycle.
- R5: A beat whose rx_src is not the expected partner drives src_err high in that same cycle. Its data is not added, and rx_ready stays high.
- R6: At the first m with 2^m ≤ i, the node raises tx_valid with tx_dst = i-2^m and tx_data = running sum. It holds both stable until tx_ready, then enters DONE.
- R7: Node 0 never raises tx_valid. After all n dimensions it raises done with the total on result.
- R8: Every partner index, whether receive or send, differs from i in exactly one bit.
- R9: The sum is DATA_W+n bits wide, so 2^n values that are all at the maximum add up exactly.
- R10: start has no effect while busy. In DONE, done and result hold until a start pulse, which begins a fresh reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a reduction (IDLE or DONE only) |
| node_id | input | DIM_N | This node's index, captured on start |
| own_val | input | DATA_W | This node's contribution, captured on start |
| rx_valid | input | 1 | Incoming partial sum is present |
| rx_ready | output | 1 | Node waits for a partial sum |
| rx_src | input | DIM_N | Index of the sending node |
| rx_data | input | DATA_W+DIM_N | Incoming partial sum |
| tx_valid | output | 1 | Outgoing partial sum is present |
| tx_ready | input | 1 | Destination accepts the outgoing sum |
| tx_dst | output | DIM_N | Index of the destination node |
| tx_data | output | DATA_W+DIM_N | Outgoing partial sum |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | Reduction finished for this node |
| src_err | output | 1 | Current receive beat has an unexpected source |
| result | output | DATA_W+DIM_N | Running sum; the total on node 0 when done |

## Verification
The hold assertion on the send side assumes that a partner only completes a transfer by raising tx_ready. It makes no claim about what happens before that. The error assertion assumes that a rejected beat cannot also be a start, which holds because start is ignored in RECV. The stimulus keeps every incoming partial sum within what a real subtree of that size could produce, so sums never exceed the width. In the mesh of eight nodes, start is raised only after every node has reported done.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STEP,
        ST_RECV,
        ST_SEND,
        ST_DONE
    } hcr_state_e;

endpackage

// File: rtl/hcr_dim_cnt.sv
module hcr_dim_cnt #(
    parameter int DIM_N = 4,
    localparam int LW = $clog2(DIM_N + 1),
    localparam int MW = (DIM_N > 1) ? $clog2(DIM_N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          dec,
    output logic [MW-1:0] cur_m,
    output logic          exhausted
);

    logic [LW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= LW'(DIM_N);
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign exhausted = (left_q == '0);
    assign cur_m     = MW'(left_q - 1'b1);

    // R2: a start loads the top dimension
    p_dim_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (left_q == LW'(DIM_N)));

    // R3: dimensions are walked downward one at a time
    p_dim_desc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load && !exhausted) |=> (left_q == LW'($past(left_q) - 1'b1)));

endmodule

// File: rtl/hcr_partner.sv
module hcr_partner #(
    parameter int DIM_N = 4,
    localparam int MW = (DIM_N > 1) ? $clog2(DIM_N) : 1
) (
    input  logic [DIM_N-1:0] id,
    input  logic [MW-1:0]    cur_m,
    output logic             recv_side,
    output logic [DIM_N-1:0] partner
);

    logic [DIM_N-1:0] dim_bit;

    always_comb begin
        dim_bit   = DIM_N'(1) << cur_m;
        recv_side = (dim_bit > id);
        // When 2^m > id, bit m of id is clear: adding sets it.
        // At the first 2^m <= id, bit m is the top set bit: subtracting clears it.
        partner   = recv_side ? (id | dim_bit) : (id & ~dim_bit);
    end

endmodule

// File: rtl/hcr_accum.sv
module hcr_accum #(
    parameter int DATA_W = 8,
    parameter int SUM_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] own_val,
    input  logic              add,
    input  logic [SUM_W-1:0]  addend,
    output logic [SUM_W-1:0]  sum
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum <= '0;
        end else if (load) begin
            sum <= SUM_W'(own_val);
        end else if (add) begin
            sum <= sum + addend;
        end
    end

    // R2: the own contribution appears right after a load
    p_acc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (sum == SUM_W'($past(own_val))));

endmodule

// File: rtl/hcube_reduce_node.sv
module hcube_reduce_node
    import hcr_pkg::*;
#(
    parameter int DIM_N  = 4,
    parameter int DATA_W = 8,
    localparam int SUM_W = DATA_W + DIM_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DIM_N-1:0]  node_id,
    input  logic [DATA_W-1:0] own_val,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [DIM_N-1:0]  rx_src,
    input  logic [SUM_W-1:0]  rx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [DIM_N-1:0]  tx_dst,
    output logic [SUM_W-1:0]  tx_data,
    output logic              busy,
    output logic              done,
    output logic              src_err,
    output logic [SUM_W-1:0]  result
);

    localparam int MW = (DIM_N > 1) ? $clog2(DIM_N) : 1;

    hcr_state_e       state_q, state_d;
    logic [DIM_N-1:0] id_q;
    logic [MW-1:0]    cur_m;
    logic             exhausted;
    logic             recv_side;
    logic [DIM_N-1:0] partner;
    logic [SUM_W-1:0] sum;
    logic             start_take;
    logic             take_beat;

    // ---------------- datapath pieces ----------------
    hcr_dim_cnt #(.DIM_N(DIM_N)) u_dim (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_take),
        .dec       (take_beat),
        .cur_m     (cur_m),
        .exhausted (exhausted)
    );

    hcr_partner #(.DIM_N(DIM_N)) u_partner (
        .id        (id_q),
        .cur_m     (cur_m),
        .recv_side (recv_side),
        .partner   (partner)
    );

    hcr_accum #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (start_take),
        .own_val (own_val),
        .add     (take_beat),
        .addend  (rx_data),
        .sum     (sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            id_q <= '0;
        end else if (start_take) begin
            id_q <= node_id;
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_STEP;
            ST_STEP: begin
                if (exhausted)      state_d = ST_DONE;
                else if (recv_side) state_d = ST_RECV;
                else                state_d = ST_SEND;
            end
            ST_RECV: if (take_beat) state_d = ST_STEP;
            ST_SEND: if (tx_ready)  state_d = ST_DONE;
            ST_DONE: if (start)     state_d = ST_STEP;
            default:                state_d = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        start_take = start && (state_q == ST_IDLE || state_q == ST_DONE);
        rx_ready   = (state_q == ST_RECV);
        tx_valid   = (state_q == ST_SEND);
        busy       = (state_q == ST_STEP) || (state_q == ST_RECV) || (state_q == ST_SEND);
        done       = (state_q == ST_DONE);
        take_beat  = rx_ready && rx_valid && (rx_src == partner);
        src_err    = rx_ready && rx_valid && (rx_src != partner);
        tx_dst     = partner;
        tx_data    = sum;
        result     = sum;
    end

    // ---------------- assertions ----------------
    // R5: a rejected beat leaves the sum alone and the node still waits
    p_err_noacc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        src_err |=> ($stable(result) && rx_ready));

    // R6: outgoing sum and destination hold until accepted
    p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_dst)));

    // R7: node 0 never sends
    p_node0_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (id_q != '0));

    // R8: send partner is a direct cube neighbour
    p_tx_onebit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($countones(tx_dst ^ id_q) == 1));

    // R8: accepted source is a direct cube neighbour
    p_rx_onebit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_beat |-> ($countones(rx_src ^ id_q) == 1));

    // R10: start while busy does not reload the sum
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !take_beat) |=> $stable(result));

endmodule

// File: tb/hcube_reduce_node_test.sv
module hcube_reduce_node_test;

    localparam int N      = 4;
    localparam int W      = 8;
    localparam int SW     = W + N;
    localparam int MN     = 3;
    localparam int MNODES = 1 << MN;
    localparam int MSW    = W + MN;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          start;
    logic [N-1:0]  node_id;
    logic [W-1:0]  own_val;
    logic          rx_valid;
    logic          rx_ready;
    logic [N-1:0]  rx_src;
    logic [SW-1:0] rx_data;
    logic          tx_valid;
    logic          tx_ready;
    logic [N-1:0]  tx_dst;
    logic [SW-1:0] tx_data;
    logic          busy;
    logic          done;
    logic          src_err;
    logic [SW-1:0] result;

    hcube_reduce_node #(.DIM_N(N), .DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .node_id(node_id), .own_val(own_val),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_src(rx_src), .rx_data(rx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_dst(tx_dst), .tx_data(tx_data),
        .busy(busy), .done(done), .src_err(src_err), .result(result)
    );

    // ---------------- mesh of 2^MN nodes on an ideal crossbar ----------------
    logic           m_start;
    logic [W-1:0]   m_own  [MNODES];
    logic           m_rxv  [MNODES];
    logic           m_rxr  [MNODES];
    logic [MN-1:0]  m_rxs  [MNODES];
    logic [MSW-1:0] m_rxd  [MNODES];
    logic           m_txv  [MNODES];
    logic           m_txr  [MNODES];
    logic [MN-1:0]  m_txd  [MNODES];
    logic [MSW-1:0] m_txdat[MNODES];
    logic           m_busy [MNODES];
    logic           m_done [MNODES];
    logic           m_err  [MNODES];
    logic [MSW-1:0] m_res  [MNODES];
    logic           m_err_seen;

    for (genvar g = 0; g < MNODES; g++) begin : g_mesh
        hcube_reduce_node #(.DIM_N(MN), .DATA_W(W)) node_i (
            .clk(clk), .rst_n(rst_n), .start(m_start), .node_id(MN'(g)), .own_val(m_own[g]),
            .rx_valid(m_rxv[g]), .rx_ready(m_rxr[g]), .rx_src(m_rxs[g]), .rx_data(m_rxd[g]),
            .tx_valid(m_txv[g]), .tx_ready(m_txr[g]), .tx_dst(m_txd[g]), .tx_data(m_txdat[g]),
            .busy(m_busy[g]), .done(m_done[g]), .src_err(m_err[g]), .result(m_res[g])
        );
    end

    // Highest-index sender wins each destination; a sender is released
    // only when it won and its destination is ready.
    always_comb begin
        for (int j = 0; j < MNODES; j++) begin
            m_rxv[j] = 1'b0;
            m_rxs[j] = '0;
            m_rxd[j] = '0;
        end
        for (int j = 0; j < MNODES; j++) begin
            for (int k = 0; k < MNODES; k++) begin
                if (m_txv[k] && m_txd[k] == MN'(j)) begin
                    m_rxv[j] = 1'b1;
                    m_rxs[j] = MN'(k);
                    m_rxd[j] = m_txdat[k];
                end
            end
        end
        for (int k = 0; k < MNODES; k++) begin
            m_txr[k] = m_txv[k] && (m_rxs[m_txd[k]] == MN'(k)) && m_rxr[m_txd[k]];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < MNODES; k++) begin
            if (rst_n && m_err[k]) m_err_seen <= 1'b1;
        end
    end

    // ---------------- checking ----------------
    int vecs = 0;
    int errs = 0;

    task automatic check(input string tag, input longint act, input longint exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int onebit_ok(input int a, input int b);
        int x = a ^ b;
        return (x != 0 && (x & (x - 1)) == 0) ? 1 : 0;
    endfunction

    task automatic wait_rx(input string tag);
        int n = 0;
        while (!rx_ready && n < 40) begin
            @(negedge clk);
            n++;
        end
        check({tag, " rx_ready"}, rx_ready, 1);
    endtask

    task automatic beat(input int src, input int d, input bit exp_err, input string tag);
        rx_valid = 1'b1;
        rx_src   = N'(src);
        rx_data  = SW'(d);
        #1;
        check({tag, " src_err"}, src_err, exp_err);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // Runs one reduction on the stand-alone node, acting as its partners.
    task automatic run_node(input int id, input int own, input bit maxed, input string tag);
        int  sum;
        bit  sent;
        bit  probed;
        sent   = 1'b0;
        probed = 1'b0;
        node_id = N'(id);
        own_val = W'(own);
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sum   = own;
        check({tag, " R2 own value loaded"}, result, own);
        for (int m = N - 1; m >= 0; m--) begin
            if ((1 << m) > id) begin
                int d;
                d = maxed ? 255 * (1 << m) : int'($urandom_range(0, 255));
                wait_rx(tag);
                if (!probed && m > 0) begin
                    probed  = 1'b1;
                    // R3/R5: a lower neighbour arriving early is rejected
                    // R10: start pulsed in the same cycle is ignored
                    node_id = '0;
                    own_val = 8'hAA;
                    start   = 1'b1;
                    beat(id ^ 1, 77, 1'b1, {tag, " R5 wrong source"});
                    start = 1'b0;
                    check({tag, " R5 sum unchanged"}, result, sum);
                    check({tag, " R10 start ignored, still waiting"}, rx_ready, 1);
                end
                check({tag, " R8 rx partner one bit"}, onebit_ok(id, id + (1 << m)), 1);
                beat(id + (1 << m), d, 1'b0, {tag, " R3 expected source"});
                sum += d;
                check({tag, " R4 accumulated"}, result, sum);
            end else begin
                int n = 0;
                while (!tx_valid && n < 40) begin
                    @(negedge clk);
                    n++;
                end
                check({tag, " R6 tx_valid"}, tx_valid, 1);
                check({tag, " R6 tx_dst"}, tx_dst, id - (1 << m));
                check({tag, " R6 tx_data"}, tx_data, sum);
                check({tag, " R8 tx partner one bit"}, onebit_ok(id, int'(tx_dst)), 1);
                repeat (2) @(negedge clk);
                check({tag, " R6 held valid"}, tx_valid, 1);
                check({tag, " R6 held data"}, tx_data, sum);
                tx_ready = 1'b1;
                @(negedge clk);
                tx_ready = 1'b0;
                check({tag, " R10 done after send"}, done, 1);
                check({tag, " R6 valid dropped"}, tx_valid, 0);
                sent = 1'b1;
                break;
            end
        end
        if (!sent) begin
            int  n = 0;
            bit  saw_tx = 1'b0;
            while (!done && n < 40) begin
                if (tx_valid) saw_tx = 1'b1;
                @(negedge clk);
                n++;
            end
            check({tag, " R7 node 0 done"}, done, 1);
            check({tag, " R7 node 0 silent"}, saw_tx, 0);
            check({tag, " R7/R9 total"}, result, sum);
        end
        repeat (2) @(negedge clk);
        check({tag, " R10 result held"}, result, sum);
        check({tag, " R10 done held"}, done, 1);
    endtask

    task automatic mesh_round(input bit maxed, input string tag);
        int exp = 0;
        int n = 0;
        bit all_done;
        for (int g = 0; g < MNODES; g++) begin
            m_own[g] = maxed ? 8'hFF : W'($urandom_range(0, 255));
            exp += int'(m_own[g]);
        end
        m_start = 1'b1;
        @(negedge clk);
        m_start  = 1'b0;
        all_done = 1'b0;
        while (!all_done && n < 200) begin
            @(negedge clk);
            n++;
            all_done = 1'b1;
            for (int g = 0; g < MNODES; g++) if (!m_done[g]) all_done = 1'b0;
        end
        check({tag, " R6/R7 all nodes done"}, all_done, 1);
        check({tag, " R7/R9 node 0 total"}, m_res[0], exp);
    endtask

    initial begin
        #(20 * 150000);
        vecs++;
        errs++;
        $display("FAIL watchdog: actual 0 expected 1 (run finished)");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; node_id = '0; own_val = '0;
        rx_valid = 1'b0; rx_src = '0; rx_data = '0; tx_ready = 1'b0;
        m_start = 1'b0; m_err_seen = 1'b0;
        for (int g = 0; g < MNODES; g++) m_own[g] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset rx_ready", rx_ready, 0);
        check("R1 reset tx_valid", tx_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 rx_ready", rx_ready, 0);
        check("R1 tx_valid", tx_valid, 0);
        check("R1 done", done, 0);
        check("R1 busy", busy, 0);
        check("R1 src_err", src_err, 0);
        check("R1 result", result, 0);

        run_node(3, 5, 1'b0, "n4 i3 order 11 then 7");
        run_node(0, 255, 1'b1, "R9 node 0 all max");
        run_node(0, 17, 1'b0, "node 0 random");
        run_node(15, 9, 1'b0, "R6 node 15 sends at once");
        run_node(8, 200, 1'b0, "node 8");
        for (int t = 0; t < 30; t++) begin
            run_node(int'($urandom_range(0, 15)), int'($urandom_range(0, 255)), 1'b0, "random node");
        end

        mesh_round(1'b1, "mesh R9 all max");
        for (int r = 0; r < 15; r++) mesh_round(1'b0, "mesh random");
        check("R5 no spurious source error in mesh", m_err_seen, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule